// File: doc/BRIEF.md
# Seeded Alarm Countdown

This block is a 24-bit down counter paced by a once-per-second tick. A host loads a seed value through a register-style write port, and the seed goes straight into the counter. While the counter is enabled and the tick source is running, each tick takes one from the count. The step that brings the count to zero raises a sticky alarm flag. The count then stays at zero until the host writes a new seed. The host acknowledges the alarm with a clear strobe.

A separate control write sets two bits. The first is the counter enable. The second is an active-low run bit for the tick source, where a 1 stops it. When the enable bit is 0, the counter never moves, and its storage behaves as an ordinary read/write register. The flag is raised on every alarm event that occurs while the counter is enabled, and no other setting gates it.

Top module: `alarm_countdown`

## Requirements
- R1: After reset the count is 0, the alarm flag is 0, the enable bit is 0 and the stop bit is 0 (tick source running).
- R2: A seed write loads the value on `seed_wdata` into the counter at the next clock edge, whatever the control bits are. It takes priority over a tick arriving in the same cycle.
- R3: When the enable bit is 1, the stop bit is 0 and the count is nonzero, a cycle with `tick` high decrements the count by exactly one. A cycle without `tick` leaves the count unchanged.
- R4: The decrement that brings the count from 1 to 0 sets the alarm flag at the same clock edge. After that the count stays at 0 on further ticks and never wraps.
- R5: A seed of 0 written while the counter is enabled does not start the counter, and it never sets the flag.
- R6: While the enable bit is 0, ticks have no effect, and the value last written is read back unchanged on `count`.
- R7: While the stop bit is 1, ticks are ignored. Clearing the stop bit lets counting resume from the held value.
- R8: The alarm flag stays at 1 until a cycle with `flag_clr` high, which returns it to 0 at the next edge.
- R9: If an alarm event and `flag_clr` occur in the same cycle, the flag ends that cycle at 1.
- R10: A control write (`ctrl_we` high) captures `ctrl_enable` and `ctrl_stop` together. Until the next control write, both bits keep their captured values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse from the 1 Hz timebase |
| seed_we | input | 1 | Seed write strobe |
| seed_wdata | input | 24 | Seed value to load |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_enable | input | 1 | Counter enable value to write |
| ctrl_stop | input | 1 | Tick-source stop value to write (1 = stopped) |
| flag_clr | input | 1 | Alarm flag acknowledge |
| count | output | 24 | Current counter value or stored word |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
Seeds from 1 to 8 are each counted all the way down with ticks. Between ticks the bench inserts idle cycles, and it keeps ticking after zero is reached. This separates a correct decrement from a missing decrement, a double step, a flag raised one step early or late, and a wrap below zero. The same tick patterns are then replayed with the counter disabled, with the tick source stopped, and with a zero seed, which shows whether each gate really blocks counting. Same-cycle collisions are also driven: seed write against tick, clear against alarm event, and control write against tick. These expose which operation wins in each case.

// File: rtl/alarm_cd_pkg.sv
package alarm_cd_pkg;
  typedef struct packed {
    logic enable;
    logic stop;
  } cd_ctrl_t;
endpackage

// File: rtl/alarm_cd_ctrl.sv
module alarm_cd_ctrl
  import alarm_cd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ctrl_we,
  input  logic     ctrl_enable,
  input  logic     ctrl_stop,
  output cd_ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.enable <= ctrl_enable;
      ctrl_q.stop   <= ctrl_stop;
    end
  end

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
  assert_ctrl_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q.enable == $past(ctrl_enable)) && (ctrl_q.stop == $past(ctrl_stop)));
endmodule

// File: rtl/alarm_cd_counter.sv
module alarm_cd_counter
  import alarm_cd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  cd_ctrl_t         ctrl,
  input  logic             seed_we,
  input  logic [CNT_W-1:0] seed_wdata,
  output logic [CNT_W-1:0] count,
  output logic             run_step,
  output logic             zero_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  logic count_live;
  assign count_live = ctrl.enable && !ctrl.stop && (count != '0);
  assign run_step   = tick && count_live && !seed_we;
  assign zero_evt   = run_step && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (seed_we)  count <= seed_wdata;
    else if (run_step) count <= step_down(count);
  end

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> count == $past(seed_wdata));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |=> count == $past(count) - ONE);
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && !seed_we |=> count == '0);
  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable && !seed_we |=> $stable(count));
  assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.stop && !seed_we |=> $stable(count));
endmodule

// File: rtl/alarm_cd_flag.sv
module alarm_cd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr)     flag <= 1'b0;
  end

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_evt |=> !flag);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
endmodule

// File: rtl/alarm_countdown.sv
module alarm_countdown
  import alarm_cd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             seed_we,
  input  logic [CNT_W-1:0] seed_wdata,
  input  logic             ctrl_we,
  input  logic             ctrl_enable,
  input  logic             ctrl_stop,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             alarm_flag
);
  cd_ctrl_t ctrl_q;
  logic     run_step;
  logic     zero_evt;

  alarm_cd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
    .ctrl_enable(ctrl_enable), .ctrl_stop(ctrl_stop), .ctrl_q(ctrl_q)
  );

  alarm_cd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl_q),
    .seed_we(seed_we), .seed_wdata(seed_wdata),
    .count(count), .run_step(run_step), .zero_evt(zero_evt)
  );

  alarm_cd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(zero_evt), .clr(flag_clr), .flag(alarm_flag)
  );

  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> (count == '0) && ctrl_q.enable);
  assert_zero_seed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && !seed_we |-> !zero_evt);
  assert_step_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |-> tick && ctrl_q.enable && !ctrl_q.stop);
endmodule

// File: tb/alarm_countdown_bench.sv
module alarm_countdown_bench;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, seed_we = 1'b0, ctrl_we = 1'b0;
  logic         ctrl_enable = 1'b0, ctrl_stop = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] seed_wdata = '0;
  logic [W-1:0] count;
  logic         alarm_flag;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] m_cnt = '0;
  logic         m_flag = 1'b0, m_en = 1'b0, m_stop = 1'b0;

  always #2.5 clk = ~clk;

  alarm_countdown #(.CNT_W(W)) u_alarm_countdown (
    .clk(clk), .rst_n(rst_n), .tick(tick), .seed_we(seed_we),
    .seed_wdata(seed_wdata), .ctrl_we(ctrl_we), .ctrl_enable(ctrl_enable),
    .ctrl_stop(ctrl_stop), .flag_clr(flag_clr), .count(count), .alarm_flag(alarm_flag)
  );

  task automatic check(input string tag);
    checks++;
    if (count !== m_cnt || alarm_flag !== m_flag) begin
      errors++;
      $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
               tag, count, alarm_flag, m_cnt, m_flag);
    end
  endtask

  // one cycle: drive, clock, update model from the requirements, check
  task automatic step(input logic t, input logic sw, input logic [W-1:0] sd,
                      input logic cw, input logic ce, input logic cs,
                      input logic cl, input string tag);
    logic ev;
    tick = t; seed_we = sw; seed_wdata = sd;
    ctrl_we = cw; ctrl_enable = ce; ctrl_stop = cs; flag_clr = cl;
    @(posedge clk);
    #1;
    ev = 1'b0;
    if (sw) m_cnt = sd;
    else if (t && m_en && !m_stop && m_cnt != 0) begin
      m_cnt = m_cnt - 1;
      ev = (m_cnt == 0);
    end
    if (ev) m_flag = 1'b1;
    else if (cl) m_flag = 1'b0;
    if (cw) begin m_en = ce; m_stop = cs; end
    tick = 0; seed_we = 0; ctrl_we = 0; flag_clr = 0;
    check(tag);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1");
    rst_n = 1'b1;
    #4;
    // R1: enable resets to 0, so ticks after a seed write do nothing
    step(0, 1, 24'd3, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, 0, 0, "R1");
    // R6: plain storage while disabled
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 24'hA50000 + 24'(i * 4099), 0, 0, 0, 0, "R6");
      step(1, 0, 0, 0, 0, 0, 0, "R6");
      step(1, 0, 0, 0, 0, 0, 0, "R6");
    end
    // R10: enable, running
    step(0, 0, 0, 1, 1, 0, 0, "R10");
    // R3/R4/R8: sweep seeds, with gaps and overrun ticks
    for (int s = 1; s <= 8; s++) begin
      step(0, 1, 24'(s), 0, 0, 0, 0, "R2");
      for (int k = 0; k < s + 3; k++) begin
        step(1, 0, 0, 0, 0, 0, 0, "R3_R4");
        if (k % 2 == 0) step(0, 0, 0, 0, 0, 0, 0, "R3");
      end
      repeat (3) step(0, 0, 0, 0, 0, 0, 0, "R8");
      step(0, 0, 0, 0, 0, 0, 1, "R8");
    end
    // R5: zero seed while enabled
    step(0, 1, 24'd0, 0, 0, 0, 0, "R5");
    repeat (4) step(1, 0, 0, 0, 0, 0, 0, "R5");
    // R7: stopped tick source
    step(0, 1, 24'd5, 1, 1, 1, 0, "R7");
    repeat (4) step(1, 0, 0, 0, 0, 0, 0, "R7");
    step(1, 0, 0, 1, 1, 0, 0, "R7");
    repeat (5) step(1, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    // R2: seed write against tick
    step(1, 1, 24'hFFFFFF, 0, 0, 0, 0, "R2");
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 1, 24'd2, 0, 0, 0, 0, "R2");
    // R9: alarm event and clear together
    step(1, 0, 0, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 1, 24'd1, 0, 0, 0, 1, "R8");
    step(1, 0, 0, 0, 0, 0, 1, "R9");
    // R10: control write same cycle as tick uses old bits
    step(0, 1, 24'd4, 0, 0, 0, 1, "R2");
    step(1, 0, 0, 1, 0, 0, 0, "R10");
    step(1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 1, 24'h123456, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, 0, 0, "R6");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule